// File: doc/BRIEF.md
# Multi-mode 8-bit timer counter

This block is an up-counter with one compare channel. It advances once on each cycle where an external prescaler raises its count-enable tick. A two-bit mode field selects how the count behaves. In free-running mode it wraps at the top of its range. In clear-on-compare mode it returns to zero after it equals the compare value. In single-slope PWM mode it sweeps the full range and takes a double-buffered compare value. Software can load the counter, the compare value and the mode at any time. It reads the count and two sticky flags (overflow and compare) and clears the flags with a two-bit strobe.

The compare-match event is a one-cycle pulse meant for a separate waveform unit downstream. The bottom event is a one-cycle pulse marking every tick that leaves the count at zero. A counter load blocks compare detection for the next tick. Because of this, loading the compare value itself never raises a spurious match.

Top module: `tick_timer8`

## Requirements
- R1: A synchronous active-low reset clears the count, the mode (to free-running), the compare value and its buffer, both flags and both event outputs.
- R2: The count changes only on a cycle where `tick` is high or `cnt_wr` is high; with neither it holds.
- R3: In free-running mode (code 0) a tick at 0xFF gives 0x00. At that same edge `ovf_flag` and `bottom_evt` rise. A compare match never clears the count in this mode.
- R4: A counter load takes effect at the next edge. No match is detected on the load cycle or on the next tick after it. Loading the compare value therefore gives no `match_evt`, no `cmp_flag` and, in clear-on-compare mode, no clear.
- R5: In clear-on-compare mode (code 2), a tick while the count equals the compare value sends the count to 0x00. At that same edge `match_evt` pulses for one cycle and `cmp_flag` rises.
- R6: In clear-on-compare mode a compare write is used from the next cycle onward. If it is below the count, the counter runs up to 0xFF, wraps to 0x00 and sets `ovf_flag`, and only then can it match.
- R7: In single-slope PWM mode (code 3) a match pulses `match_evt` and sets `cmp_flag` but does not clear the count. `ovf_flag` rises at the edge where the count becomes 0xFF, and the count then wraps to 0x00.
- R8: In PWM mode a compare write goes only to a buffer. The active compare value is loaded from the buffer at the edge where the count becomes 0xFF. In the other modes a compare write updates the active value directly.
- R9: Flags are sticky. `flag_clr` bit 0 clears `ovf_flag` and bit 1 clears `cmp_flag`. A set in the same cycle as a clear leaves the flag set.
- R10: Mode code 1 behaves exactly as free-running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from prescaler |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 8 | Counter load value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code (0 free, 1 free, 2 clear-on-compare, 3 PWM) |
| flag_clr | input | 2 | Flag clear strobes: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current count |
| match_evt | output | 1 | One-cycle compare-match pulse |
| bottom_evt | output | 1 | One-cycle pulse when a tick leaves the count at zero |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The bench builds the block with its default width of 8 bits. With that width a complete sweep of the count takes only 256 ticks. The bench can therefore follow a PWM-mode buffered compare write through a whole period to the load at 0xFF and then watch the new value match. At that width the bench also reaches the wrap paths in every mode: a compare value set below the count, a compare value of 0xFF in clear-on-compare mode, and a clear strobe in the same cycle as an overflow.

// File: rtl/tmr8_pkg.sv
// Shared types for the multi-mode timer.
// Assumes a two-bit mode code written by software.
package tmr8_pkg;
    typedef enum logic [1:0] {
        MD_FREE   = 2'd0,
        MD_ALT    = 2'd1,
        MD_CLRCMP = 2'd2,
        MD_PWM    = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr8_cmp_store.sv
// Compare value storage: a software-visible buffer and the active value
// used by the matcher. Outside PWM mode the active value follows writes
// directly. In PWM mode it loads only when the counter reaches its top.
// Assumes load_top is a single-cycle pulse from the counter core.
module tmr8_cmp_store
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         load_top,
    output logic [W-1:0] cmp_act
);
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         pwm_mode;

    // Decode whether the double buffer is in use.
    always_comb pwm_mode = (mode == MD_PWM);

    // Capture software writes into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (cmp_wr) buf_q <= cmp_wdata;
    end

    // Update the active value: direct outside PWM, at top inside PWM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!pwm_mode) begin
            act_q <= cmp_wr ? cmp_wdata : buf_q;
        end else if (load_top) begin
            act_q <= cmp_wr ? cmp_wdata : buf_q;
        end
    end

    assign cmp_act = act_q;

    // R8
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && !load_top) |=> $stable(act_q));

    // R8
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && cmp_wr) |=> (act_q == $past(cmp_wdata)));
endmodule

// File: rtl/tmr8_count_core.sv
// Counter datapath with matcher and event generation. It advances on tick,
// loads on a bus write, and blocks matching on the load cycle and on the
// first tick after it. The count clears after a match in clear-on-compare
// mode. Produces the combinational flag-set requests and the registered
// event pulses. Assumes at most one load per cycle.
module tmr8_count_core
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] cmp_act,
    output logic [W-1:0] count,
    output logic         ovf_set,
    output logic         cmp_set,
    output logic         load_top,
    output logic         match_evt,
    output logic         bottom_evt
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] PRE_MAX = CNT_MAX - ONE;

    logic [W-1:0] count_q;
    logic [W-1:0] cnt_nxt;
    logic         blk_q;
    logic         adv;
    logic         hit;
    logic         pwm_mode;
    logic         ctc_mode;
    logic         match_q;
    logic         bottom_q;

    // Decode mode and qualify the tick against a concurrent load.
    always_comb begin
        pwm_mode = (mode == MD_PWM);
        ctc_mode = (mode == MD_CLRCMP);
        adv      = tick && !cnt_wr;
    end

    // Detect a compare match unless a recent load blocks it.
    always_comb hit = adv && !blk_q && (count_q == cmp_act);

    // Choose the next count: load, clear on match, increment, or hold.
    always_comb begin
        if (cnt_wr)              cnt_nxt = cnt_wdata;
        else if (adv && hit && ctc_mode) cnt_nxt = '0;
        else if (adv)            cnt_nxt = count_q + ONE;
        else                     cnt_nxt = count_q;
    end

    // Form flag-set requests and the buffer load strobe.
    always_comb begin
        load_top = adv && pwm_mode && (count_q == PRE_MAX);
        ovf_set  = pwm_mode ? load_top : (adv && (count_q == CNT_MAX));
        cmp_set  = hit;
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= cnt_nxt;
    end

    // Arm the match block on a load, release it after the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_q <= 1'b0;
        else if (cnt_wr) blk_q <= 1'b1;
        else if (tick)   blk_q <= 1'b0;
    end

    // Register the event pulses for the downstream units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= 1'b0;
            bottom_q <= 1'b0;
        end else begin
            match_q  <= hit;
            bottom_q <= adv && (cnt_nxt == '0);
        end
    end

    assign count      = count_q;
    assign match_evt  = match_q;
    assign bottom_evt = bottom_q;

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count_q));

    // R4
    load_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !match_q);

    // R4
    blocked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q |=> !match_q);

    // R3
    wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !pwm_mode && (count_q == CNT_MAX)) |=> (bottom_q && count_q == '0));
endmodule

// File: rtl/tmr8_flag_pair.sv
// Sticky flag bank: each bit is set by hardware and cleared by a software
// strobe. A set wins over a clear in the same cycle.
// Assumes set requests are single-cycle qualified pulses.
module tmr8_flag_pair #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Update one sticky bit with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set_req[i] | (flag_q[i] & ~clr_req[i]);
        end

        // R9
        set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> flag_q[i]);

        // R9
        clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_req[i]) |=> !flag_q[i]);
    end

    assign flags = flag_q;
endmodule

// File: rtl/tick_timer8.sv
// Multi-mode timer top: mode register, compare storage, counter core and
// sticky flags. Flag bit 0 is overflow, bit 1 is compare.
// Assumes tick comes from an external prescaler, one cycle wide per step.
module tick_timer8
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         mode_wr,
    input  logic [1:0]   mode_wdata,
    input  logic [1:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         match_evt,
    output logic         bottom_evt,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    tmr_mode_e    mode_q;
    logic [W-1:0] cmp_act;
    logic         ovf_set;
    logic         cmp_set;
    logic         load_top;
    logic [1:0]   flags;

    // Hold the software-selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MD_FREE;
        else if (mode_wr) mode_q <= tmr_mode_e'(mode_wdata);
    end

    tmr8_cmp_store #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .load_top  (load_top),
        .cmp_act   (cmp_act)
    );

    tmr8_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode       (mode_q),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .cmp_act    (cmp_act),
        .count      (count),
        .ovf_set    (ovf_set),
        .cmp_set    (cmp_set),
        .load_top   (load_top),
        .match_evt  (match_evt),
        .bottom_evt (bottom_evt)
    );

    tmr8_flag_pair #(.N(2)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req ({cmp_set, ovf_set}),
        .clr_req (flag_clr),
        .flags   (flags)
    );

    assign ovf_flag = flags[0];
    assign cmp_flag = flags[1];

    // R5
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CLRCMP && cmp_set) |=> (count == '0 && match_evt));

    // R7
    pwm_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_PWM && cmp_set && cmp_act != '1) |=> (count != '0));
endmodule

// File: tb/sim_tick_timer8.sv
module sim_tick_timer8;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, cnt_wr, cmp_wr, mode_wr;
    logic [7:0] cnt_wdata, cmp_wdata;
    logic [1:0] mode_wdata, flag_clr;
    logic [7:0] count;
    logic       match_evt, bottom_evt, ovf_flag, cmp_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tick_timer8 #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .flag_clr(flag_clr), .count(count),
        .match_evt(match_evt), .bottom_evt(bottom_evt),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    // mode, cmp, start, ticks, exp count, exp ovf, exp cmp flag
    localparam logic [35:0] VECS [0:9] = '{
        {2'd0, 8'h10, 8'hFE, 8'd3, 8'h01, 1'b1, 1'b0},
        {2'd0, 8'h05, 8'h03, 8'd4, 8'h07, 1'b0, 1'b1},
        {2'd2, 8'h05, 8'h03, 8'd4, 8'h01, 1'b0, 1'b1},
        {2'd2, 8'h05, 8'h05, 8'd2, 8'h07, 1'b0, 1'b0},
        {2'd2, 8'h02, 8'hFD, 8'd6, 8'h00, 1'b1, 1'b1},
        {2'd3, 8'h03, 8'h01, 8'd5, 8'h06, 1'b0, 1'b1},
        {2'd3, 8'h80, 8'hFD, 8'd3, 8'h00, 1'b1, 1'b0},
        {2'd1, 8'h02, 8'h01, 8'd3, 8'h04, 1'b0, 1'b1},
        {2'd0, 8'h07, 8'h07, 8'd1, 8'h08, 1'b0, 1'b0},
        {2'd2, 8'hFF, 8'hFE, 8'd2, 8'h00, 1'b1, 1'b1}
    };
    localparam string TAGS [0:9] = '{"R3", "R3", "R5", "R4", "R6",
                                     "R7", "R7", "R10", "R4", "R6"};

    task automatic chk(input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    // Load mode, compare and count with ticks stopped; compare is written in free mode.
    task automatic setup(input logic [1:0] md, input logic [7:0] cv, input logic [7:0] st);
        mode_wr = 1'b1; mode_wdata = 2'd0; cyc();
        mode_wr = 1'b0;
        cmp_wr = 1'b1; cmp_wdata = cv; cnt_wr = 1'b1; cnt_wdata = st; flag_clr = 2'b11;
        cyc();
        cmp_wr = 1'b0; cnt_wr = 1'b0; flag_clr = 2'b00;
        mode_wr = 1'b1; mode_wdata = md; cyc();
        mode_wr = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0; mode_wr = 1'b0;
        cnt_wdata = '0; cmp_wdata = '0; mode_wdata = '0; flag_clr = '0;
        repeat (3) cyc();
        // R1 reset state
        chk("R1", "count", count, 0);
        chk("R1", "flags", {ovf_flag, cmp_flag}, 0);
        chk("R1", "events", {match_evt, bottom_evt}, 0);
        rst_n = 1'b1;
        cyc();

        for (int v = 0; v < 10; v++) begin
            logic [35:0] e;
            e = VECS[v];
            setup(e[35:34], e[33:26], e[25:18]);
            run(int'(e[17:10]));
            chk(TAGS[v], "count", count, int'(e[9:2]));
            chk(TAGS[v], "ovf_flag", ovf_flag, int'(e[1]));
            chk(TAGS[v], "cmp_flag", cmp_flag, int'(e[0]));
        end

        // R2 hold without tick, then sparse ticks
        setup(2'd0, 8'h50, 8'h10);
        repeat (4) cyc();
        chk("R2", "hold count", count, 8'h10);
        for (int k = 0; k < 3; k++) begin
            tick = 1'b1; cyc();
            tick = 1'b0; cyc();
        end
        chk("R2", "sparse count", count, 8'h13);

        // R3 wrap edge: overflow and bottom at the same edge
        setup(2'd0, 8'h80, 8'hFF);
        tick = 1'b1; cyc(); tick = 1'b0;
        chk("R3", "wrap count", count, 0);
        chk("R3", "bottom_evt", bottom_evt, 1);
        chk("R3", "ovf at wrap", ovf_flag, 1);

        // R9 selective clear
        flag_clr = 2'b10; cyc(); flag_clr = 2'b00;
        chk("R9", "ovf kept by cmp clear", ovf_flag, 1);
        flag_clr = 2'b01; cyc(); flag_clr = 2'b00;
        chk("R9", "ovf cleared", ovf_flag, 0);

        // R9 set wins over clear
        setup(2'd0, 8'h80, 8'hFE);
        run(1);
        chk("R9", "ovf before wrap", ovf_flag, 0);
        tick = 1'b1; flag_clr = 2'b01; cyc();
        tick = 1'b0; flag_clr = 2'b00;
        chk("R9", "set beats clear", ovf_flag, 1);

        // R5 event pulse timing
        setup(2'd2, 8'h02, 8'h00);
        run(2);
        chk("R5", "pre-match count", count, 2);
        chk("R5", "no early match", match_evt, 0);
        run(1);
        chk("R5", "cleared count", count, 0);
        chk("R5", "match_evt", match_evt, 1);
        chk("R5", "bottom_evt", bottom_evt, 1);
        cyc();
        chk("R5", "match pulse ends", match_evt, 0);

        // R6 compare write while running in clear-on-compare
        setup(2'd2, 8'h40, 8'h10);
        run(2);
        cmp_wr = 1'b1; cmp_wdata = 8'h14; cyc(); cmp_wr = 1'b0;
        run(3);
        chk("R6", "immediate compare count", count, 0);
        chk("R6", "immediate compare flag", cmp_flag, 1);

        // R8 buffered compare in PWM
        setup(2'd3, 8'h04, 8'h00);
        cmp_wr = 1'b1; cmp_wdata = 8'h06; cyc(); cmp_wr = 1'b0;
        run(5);
        chk("R8", "old compare still active", cmp_flag, 1);
        flag_clr = 2'b11; cyc(); flag_clr = 2'b00;
        run(2);
        chk("R8", "new compare not yet active", cmp_flag, 0);
        run(249);
        chk("R8", "wrapped count", count, 0);
        chk("R8", "ovf over period", ovf_flag, 1);
        flag_clr = 2'b11; cyc(); flag_clr = 2'b00;
        run(5);
        chk("R8", "old compare retired", cmp_flag, 0);
        run(2);
        chk("R8", "new compare active", cmp_flag, 1);
        chk("R8", "no clear in pwm", count, 7);

        // R1 reset while running
        tick = 1'b1; rst_n = 1'b0; cyc(); tick = 1'b0;
        chk("R1", "mid-run count", count, 0);
        chk("R1", "mid-run flags", {ovf_flag, cmp_flag}, 0);
        rst_n = 1'b1;
        run(3);
        chk("R1", "mode back to free", count, 3);

        summary();
    end
endmodule